// File: doc/BRIEF.md
# Strobed Serial Register Access Master

This block is the host-side engine for a four-wire serial register link. Its lines are a serial clock, a data-out line, an active-low strobe and a data-in line. A parallel command side supplies a one-cycle start pulse, a direction flag, an 8-bit register address and a 32-bit write word. The engine serialises the request and returns the 32-bit word it reads back, together with a one-cycle done flag.

Transfers are not framed by a chip select. Instead, every transfer ends its outgoing part with a single command bit, and the strobe is held low for that bit's whole clock slot. The command bit is 1 for a write and 0 for a read.

- A write sends its data word first, then the address, then the command bit.
- A read sends the address first, then the command bit, then runs a readout of 32 clocks with the strobe back high. During the readout the remote side shifts the register contents onto data-in.

Both kinds of transfer use 41 clock pulses. Each clock phase, low or high, lasts a programmable number of system clocks, so a slow remote device can be matched without changing the system clock.

Top module: `ssr_master`

## Requirements
- R1: Out of reset and whenever the engine is idle, `sck` is 0, `stb_n` is 1, `sdo` is 0, `busy` is 0 and `done` is 0. `rdata` resets to 0.
- R2: A write (`wr_en`=1 at start) emits 41 clock pulses. On the rising edges of pulses 0 to 31, `sdo` carries `wdata` MSB first. Pulses 32 to 39 carry `addr` MSB first. Pulse 40 carries the command bit 1.
- R3: A read (`wr_en`=0 at start) emits 41 clock pulses. Pulses 0 to 7 carry `addr` MSB first and pulse 8 carries the command bit 0. Pulses 9 to 40 are readout pulses, with `sdo` held at 0 and `stb_n` at 1.
- R4: During a read, `sdi` is sampled in the last system clock of each readout high phase. The 32 samples are assembled MSB first, so the first sample becomes bit 31. The assembled word appears on `rdata` in the same cycle that `done` is 1.
- R5: Every low phase and every high phase of `sck` lasts `half_period`+1 system clocks, using the value captured at start. `sdo` changes only in the cycle in which `sck` falls, or when a transfer starts, so each bit is set up for a full low phase before the rising edge.
- R6: `stb_n` is 0 for exactly one clock slot per transfer: both phases of the command-bit pulse. It is never 0 at any other time.
- R7: `busy` rises in the cycle after start is accepted and stays 1 for exactly 82×(`half_period`+1) cycles. `done` is then 1 for exactly one cycle, with `busy` at 0, and the engine returns to idle.
- R8: `start` is accepted only while idle. A start pulse during a transfer, and any change of `wr_en`, `addr`, `wdata` or `half_period` during a transfer, has no effect on the frame or its timing.
- R9: `rdata` changes only at the end of a read. A write transfer leaves it holding the previous read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| wr_en | input | 1 | 1 = write transfer, 0 = read transfer |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Word to write |
| half_period | input | DIV_W | Each sck phase lasts half_period+1 system clocks |
| sdi | input | 1 | Serial data from the remote device |
| sck | output | 1 | Serial clock, rests low |
| sdo | output | 1 | Serial data to the remote device |
| stb_n | output | 1 | Active-low strobe, low only during the command bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer flag |
| rdata | output | DATA_W | Last word read |

## Verification
A sequencer stuck in the wrong state or miscounting bits changes the pulse count, or moves the strobed pulse away from index 40 or 8. Both are visible at the serial pins within the transfer, and also change the `busy` length seen at `done`. A broken phase counter shows up as a wrong phase length on the very first low phase, within `half_period`+2 cycles of start. Shift-order or capture errors only appear as a wrong address, data or `rdata` word when the transfer ends, so the bench decodes every frame at the pins and compares each word against an independent register image.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    // Sequencer states, visited in this order
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_CMD   = 3'd2,
        ST_READ  = 3'd3,
        ST_DONE  = 3'd4
    } ssr_state_e;

    // Per-cycle control strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;     // start accepted: capture request
        logic shift;    // advance outgoing frame by one bit
        logic drive;    // outgoing frame owns sdo
        logic capture;  // sample sdi into readout register
        logic finish;   // last readout sample: publish word
    } ssr_ctl_t;

    localparam logic CMD_WRITE = 1'b1;
    localparam logic CMD_READ  = 1'b0;

    // Pulses per transfer, identical for both directions
    function automatic int unsigned pulses_per_xfer(int unsigned aw, int unsigned dw);
        return aw + dw + 1;
    endfunction

endpackage

// File: rtl/ssr_phase_gen.sv
module ssr_phase_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             phase_end
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (run) begin
            if (cnt == div_q) cnt <= '0;
            else              cnt <= cnt + DIV_W'(1);
        end
    end

    assign phase_end = run && (cnt == div_q);

    // R5: counter never runs past the captured phase length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div_q));

    // R8: divider setting is frozen while a transfer runs
    a_r8_div_frozen: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(div_q));

endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       wr_en,
    input  logic       phase_end,
    output ssr_state_e state,
    output ssr_ctl_t   ctl,
    output logic       run,
    output logic       sck,
    output logic       stb_n
);
    localparam int CNT_W = $clog2(DATA_W + ADDR_W);

    logic [CNT_W-1:0] cnt;
    logic             wr_q;
    logic             slot_end;

    assign slot_end    = phase_end && sck;
    assign run         = (state == ST_SHIFT) || (state == ST_CMD) || (state == ST_READ);
    assign ctl.load    = (state == ST_IDLE) && start;
    assign ctl.shift   = slot_end && (state == ST_SHIFT);
    assign ctl.drive   = (state == ST_SHIFT) || (state == ST_CMD);
    assign ctl.capture = slot_end && (state == ST_READ);
    assign ctl.finish  = ctl.capture && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sck   <= 1'b0;
            stb_n <= 1'b1;
            cnt   <= '0;
            wr_q  <= 1'b0;
        end else begin
            if (run && phase_end) sck <= ~sck;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SHIFT;
                        wr_q  <= wr_en;
                        cnt   <= (wr_en == CMD_WRITE) ? CNT_W'(DATA_W + ADDR_W - 1)
                                                      : CNT_W'(ADDR_W - 1);
                    end
                end
                ST_SHIFT: begin
                    if (slot_end) begin
                        if (cnt == '0) begin
                            state <= ST_CMD;
                            stb_n <= 1'b0;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                ST_CMD: begin
                    if (slot_end) begin
                        stb_n <= 1'b1;
                        if (wr_q == CMD_WRITE) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_READ;
                            cnt   <= CNT_W'(DATA_W - 1);
                        end
                    end
                end
                ST_READ: begin
                    if (slot_end) begin
                        if (cnt == '0) state <= ST_DONE;
                        else           cnt   <= cnt - CNT_W'(1);
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: strobe low exactly while the command slot runs
    a_r6_strobe_cmd_only: assert property (@(posedge clk) disable iff (rst)
        (stb_n == 1'b0) == (state == ST_CMD));

    // R1: idle state keeps clock low and strobe high
    a_r1_idle_rest: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!sck && stb_n));

    // R8: a new frame is only ever entered from idle
    a_r8_entry_from_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && $past(state) != ST_SHIFT) |-> ($past(state) == ST_IDLE));

    // R7: done state lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

    // R2/R3: a transfer always leaves its last slot with sck low
    a_r2_end_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> !sck);

endmodule

// File: rtl/ssr_tx_shift.sv
module ssr_tx_shift
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ssr_ctl_t          ctl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sdo
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] wr_frame;
    logic [FRAME_W-1:0] rd_frame;

    // Writes: data, address, command 1. Reads: address, command 0, padding.
    assign wr_frame = {wdata, addr, CMD_WRITE};
    assign rd_frame = {addr, CMD_READ, {DATA_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
        end else if (ctl.load) begin
            frame <= (wr_en == CMD_WRITE) ? wr_frame : rd_frame;
        end else if (ctl.shift) begin
            frame <= {frame[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdo = ctl.drive & frame[FRAME_W-1];

    // R8: the outgoing frame is not reloaded while it is being sent
    a_r8_frame_locked: assert property (@(posedge clk) disable iff (rst)
        (ctl.drive && !ctl.shift && !$past(ctl.load)) |=> $stable(frame));

endmodule

// File: rtl/ssr_rx_shift.sv
module ssr_rx_shift
    import ssr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ssr_ctl_t          ctl,
    input  logic              sdi,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] next_acc;

    // First sample lands in the MSB after all shifts
    assign next_acc = {acc[DATA_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            rdata <= '0;
        end else if (ctl.capture) begin
            acc <= next_acc;
            if (ctl.finish) rdata <= next_acc;
        end
    end

    // R9: published word only moves at the end of a readout
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.finish |=> $stable(rdata));

endmodule

// File: rtl/ssr_master.sv
module ssr_master
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              sdi,
    output logic              sck,
    output logic              sdo,
    output logic              stb_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PULSES = pulses_per_xfer(ADDR_W, DATA_W);

    ssr_state_e state;
    ssr_ctl_t   ctl;
    logic       run;
    logic       phase_end;

    ssr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr_en     (wr_en),
        .phase_end (phase_end),
        .state     (state),
        .ctl       (ctl),
        .run       (run),
        .sck       (sck),
        .stb_n     (stb_n)
    );

    ssr_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .run       (run),
        .div_in    (half_period),
        .phase_end (phase_end)
    );

    ssr_tx_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .sdo   (sdo)
    );

    ssr_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .sdi   (sdi),
        .rdata (rdata)
    );

    assign busy = run;
    assign done = (state == ST_DONE);

    initial begin
        a_r2_pulse_count: assert (PULSES == 41 || ADDR_W != 8 || DATA_W != 32);
    end

    // R1: idle lines at rest
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> (!sck && stb_n && !sdo));

    // R5: data-out holds steady while the clock is high
    a_r5_sdo_hold_high: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(sdo));

    // R3: data-out quiet during readout
    a_r3_readout_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy && stb_n && $past(!stb_n)) |-> !sdo);

    // R7: busy and done never overlap, done is a single pulse
    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/sim_ssr_master.sv
module sim_ssr_master;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             wr_en = 1'b0;
    logic             sdi = 1'b0;
    logic [7:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [DIV_W-1:0] hp = '0;
    logic             sck, sdo, stb_n, busy, done;
    logic [31:0]      rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] slave_mem [256];
    logic [31:0] exp_mem [256];
    logic [31:0] last_rd = '0;

    always #5 clk = ~clk;

    ssr_master #(.ADDR_W(8), .DATA_W(32), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .half_period(hp), .sdi(sdi), .sck(sck), .sdo(sdo),
        .stb_n(stb_n), .busy(busy), .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] init_val(input int a);
        return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96;
    endfunction

    function automatic int exp_busy(input int hpv);
        return 82 * (hpv + 1);
    endfunction

    // One transfer: drive request, act as the remote device, decode the pins.
    task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input int hpv, input int inj);
        int cyc = 0, npulse = 0, cmd_idx = -1, stb_pulses = 0;
        int lo_run = 0, hi_run = 0, bad_phase = 0, sdo_moves = 0, noisy = 0, iter = 0;
        bit prev_sck = 0, prev_stb = 1, prev_sdo = 0, rd_active = 0, rd_cmd = 0, timed_out = 0;
        bit dec_w = 0;
        logic [7:0]  dec_a = '0;
        logic [31:0] dec_d = '0, rd_sr = '0, rd_at_done = '0;
        logic        bits [64];
        @(negedge clk);
        start = 1'b1; wr_en = w; addr = a; wdata = d; hp = DIV_W'(hpv);
        @(negedge clk);
        start = 1'b0;
        prev_sdo = sdo;
        while (1) begin
            if (inj >= 0 && cyc == inj) begin
                start = 1'b1; wr_en = ~w; addr = ~a; wdata = ~d; hp = DIV_W'(hpv + 2);
            end else begin
                start = 1'b0;
            end
            if (busy) cyc++;
            if (sdo != prev_sdo && !(prev_sck && !sck)) sdo_moves++;
            if (sck && !prev_sck) begin
                if (npulse < 64) bits[npulse] = sdo;
                if (!stb_n) begin
                    stb_pulses++;
                    cmd_idx = npulse;
                    dec_w = sdo;
                    rd_cmd = !sdo;
                    for (int i = npulse - 8; i < npulse; i++)
                        if (i >= 0) dec_a = {dec_a[6:0], bits[i]};
                    if (sdo && npulse >= 40) begin
                        for (int i = npulse - 40; i < npulse - 8; i++)
                            dec_d = {dec_d[30:0], bits[i]};
                        slave_mem[dec_a] = dec_d;
                    end
                end else if (cmd_idx >= 0 && sdo) begin
                    noisy++;
                end
                npulse++;
                if (lo_run != hpv + 1) bad_phase++;
                lo_run = 0;
            end
            if (!sck && prev_sck) begin
                if (hi_run != hpv + 1) bad_phase++;
                hi_run = 0;
            end
            if (sck) hi_run++; else lo_run++;
            if (stb_n && !prev_stb && rd_cmd) begin
                rd_sr = slave_mem[dec_a];
                sdi = rd_sr[31];
                rd_active = 1;
            end else if (!sck && prev_sck && rd_active) begin
                rd_sr = {rd_sr[30:0], 1'b0};
                sdi = rd_sr[31];
            end
            prev_sck = sck; prev_stb = stb_n; prev_sdo = sdo;
            if (done) begin
                rd_at_done = rdata;
                break;
            end
            iter++;
            if (iter > 4000) begin
                timed_out = 1;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        sdi = 1'b0;
        chk(!timed_out, "R7", "transfer reached done", 64'(timed_out), 64'd0);
        chk(cyc == exp_busy(hpv), "R7", "busy cycles", 64'(cyc), 64'(exp_busy(hpv)));
        chk(npulse == 41, w ? "R2" : "R3", "clock pulses", 64'(npulse), 64'd41);
        chk(stb_pulses == 1 && cmd_idx == (w ? 40 : 8), "R6", "strobed pulse index",
            64'(cmd_idx), 64'(w ? 40 : 8));
        chk(dec_w == w, w ? "R2" : "R3", "command bit", 64'(dec_w), 64'(w));
        chk(dec_a == a, w ? "R2" : "R3", "decoded address", 64'(dec_a), 64'(a));
        if (w) begin
            chk(dec_d == d, "R2", "decoded data", 64'(dec_d), 64'(d));
            chk(rd_at_done == last_rd, "R9", "rdata held over write", 64'(rd_at_done), 64'(last_rd));
            exp_mem[a] = d;
        end else begin
            chk(noisy == 0, "R3", "sdo high in readout", 64'(noisy), 64'd0);
            chk(rd_at_done == exp_mem[a], "R4", "read data at done", 64'(rd_at_done), 64'(exp_mem[a]));
            last_rd = exp_mem[a];
        end
        chk(bad_phase == 0, "R5", "phase length mismatches", 64'(bad_phase), 64'd0);
        chk(sdo_moves == 0, "R5", "sdo moved off falling edge", 64'(sdo_moves), 64'd0);
        if (inj >= 0)
            chk(dec_a == a && cyc == exp_busy(hpv), "R8", "start during busy ignored",
                64'(cyc), 64'(exp_busy(hpv)));
        @(negedge clk);
        chk(!done && !busy, "R7", "done lasts one cycle", 64'({done, busy}), 64'd0);
        chk(!sck && stb_n && !sdo, "R1", "idle lines after transfer",
            64'({sck, stb_n, sdo}), 64'b010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            slave_mem[i] = init_val(i);
            exp_mem[i] = init_val(i);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !sck && stb_n && !sdo, "R1", "reset lines",
            64'({busy, done, sck, stb_n, sdo}), 64'b00010);
        chk(rdata == 32'd0, "R1", "reset rdata", 64'(rdata), 64'd0);

        // directed corners
        xfer(1, 8'h80, 32'h8000_0001, 0, -1);
        xfer(0, 8'h80, '0, 0, -1);
        xfer(1, 8'hFF, 32'hFFFF_FFFF, 3, -1);
        xfer(0, 8'h00, '0, 1, -1);
        xfer(0, 8'hFF, '0, 2, -1);
        xfer(1, 8'h00, 32'h0000_0000, 0, 30);   // R8: start during data shift
        xfer(0, 8'h00, '0, 1, 100);             // R8: start during readout
        xfer(1, 8'h5A, 32'h1234_5678, 7, -1);
        xfer(0, 8'h5A, '0, 7, -1);

        // random mix over a small address pool
        for (int n = 0; n < 24; n++) begin
            bit          rw;
            logic [7:0]  ra;
            logic [31:0] rd;
            int          rh;
            rw = 1'($urandom_range(0, 1));
            ra = 8'($urandom_range(0, 7) * 37);
            rd = $urandom();
            rh = int'($urandom_range(0, 3));
            xfer(rw, ra, rd, rh, -1);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule